// File: doc/BRIEF.md
# Sixteen-Bit Input Capture Timer with Byte-Wide Register Access

The block holds a free-running 16-bit counter and a 16-bit capture register. When the chosen trigger fires, the counter value is copied into the capture register and a capture status flag is raised. The trigger is an edge, rising or falling as configured, of either an external pin or an internal comparator output. Both are resynchronised through a two-flop chain before edge detection.

Software sees the 16-bit counter and capture register through an 8-bit bus. A single shared high-byte holding register makes each 16-bit transfer behave as one operation. A low-byte read copies the matching high byte into the holding register in the same cycle, and a later high-byte read returns the copy. A high-byte write fills only the holding register, and the following low-byte write moves all 16 bits at once.

An interrupt mask register gates four status flags (capture, compare A, compare B, overflow) into interrupt requests, under a global enable input. A mode bit turns the capture register into the counter's wrap point (TOP). In that mode, trigger events no longer modify the capture register.

Top module: `icap_timer16`

## Requirements
- R1: On a trigger event the capture register takes the counter value and flag bit 5 is set. A source level change first sampled at clock edge k gives a capture, at edge k+2, of the counter value held just before that edge.
- R2: Control bit 0 (address 4) selects the trigger source: 0 selects the external pin, 1 selects the comparator. Edges on the source that is not selected capture nothing.
- R3: Control bit 1 selects the edge: 1 triggers on rising edges, 0 on falling edges. The opposite edge leaves the capture register unchanged.
- R4: A read of a low byte (counter at address 0, capture at address 2) copies the matching high byte into the shared holding register in that cycle. A read of a high byte (address 1 or 3) returns the holding register.
- R5: A write to a high-byte address loads only the holding register. A write to a low-byte address loads {holding register, data} into the counter or the capture register in one cycle.
- R6: The counter adds one every cycle, wraps from 0xFFFF to 0, and sets the overflow flag (bit 0) on the wrap.
- R7: With control bit 2 set, the counter goes to 0 on the cycle after it equals the capture register and sets the overflow flag. In this mode trigger events leave the capture register unchanged.
- R8: The mask register (address 5) has capture enable at bit 5, compare-B enable at bit 2, compare-A enable at bit 1 and overflow enable at bit 0. Bits 7:6 and 4:3 read as zero, and all bits reset to zero.
- R9: Each interrupt output is high only when its mask bit, its flag bit and the global enable input are all high.
- R10: The flag register (address 6) uses the same bit positions as the mask. The compare-A and compare-B hit inputs set their flags. Writing one to a flag bit clears it, and a set in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (drives the holding-register side effect) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| cap_pin | input | 1 | External capture pin, asynchronous |
| cmp_out | input | 1 | Comparator output used as alternate trigger, asynchronous |
| cmpa_hit | input | 1 | Compare-A match pulse |
| cmpb_hit | input | 1 | Compare-B match pulse |
| gie | input | 1 | Global interrupt enable |
| irq_cap | output | 1 | Capture interrupt request |
| irq_cmpa | output | 1 | Compare-A interrupt request |
| irq_cmpb | output | 1 | Compare-B interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
Captures are driven with random counter preloads, random delays before the trigger, and every combination of source and edge. Each trial also moves the source that is not selected and then drives the opposite edge, so a source-select or polarity fault shows up as an unexpected capture. Directed cases separate a true atomic read from a raw one:
- a counter read taken just below a high-byte rollover must return the latched high byte;
- a lone high-byte write must not disturb the counter;
- TOP mode must wrap at a small capture value while ignoring triggers.

Interrupt gating is checked against the global enable, the mask and the flags one at a time.

// File: rtl/icap_pkg.sv
package icap_pkg;
    localparam int BUS_W = 8;
    localparam int CNT_W = 2 * BUS_W;
    localparam int ADR_W = 3;

    localparam logic [ADR_W-1:0] A_CNT_LO = 3'd0;
    localparam logic [ADR_W-1:0] A_CNT_HI = 3'd1;
    localparam logic [ADR_W-1:0] A_CAP_LO = 3'd2;
    localparam logic [ADR_W-1:0] A_CAP_HI = 3'd3;
    localparam logic [ADR_W-1:0] A_CTRL   = 3'd4;
    localparam logic [ADR_W-1:0] A_MASK   = 3'd5;
    localparam logic [ADR_W-1:0] A_FLAG   = 3'd6;

    localparam int B_CAP  = 5;
    localparam int B_CMPB = 2;
    localparam int B_CMPA = 1;
    localparam int B_OVF  = 0;
    localparam logic [BUS_W-1:0] IRQ_BITS = 8'h27;

    localparam int C_SRC  = 0;
    localparam int C_RISE = 1;
    localparam int C_TOP  = 2;
    localparam int CTRL_W = 3;
endpackage

// File: rtl/icap_sync_edge.sv
module icap_sync_edge #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic cmp_raw,
    input  logic src_cmp,
    input  logic rise_sel,
    output logic trig
);
    typedef struct packed {
        logic [SYNC_N-1:0] pin_sh;
        logic [SYNC_N-1:0] cmp_sh;
        logic              pin_prev;
        logic              cmp_prev;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic lvl, prv;

    always_comb begin
        st_d          = st_q;
        st_d.pin_sh   = {st_q.pin_sh[SYNC_N-2:0], pin_raw};
        st_d.cmp_sh   = {st_q.cmp_sh[SYNC_N-2:0], cmp_raw};
        st_d.pin_prev = st_q.pin_sh[SYNC_N-1];
        st_d.cmp_prev = st_q.cmp_sh[SYNC_N-1];
        lvl  = src_cmp ? st_q.cmp_sh[SYNC_N-1] : st_q.pin_sh[SYNC_N-1];
        prv  = src_cmp ? st_q.cmp_prev : st_q.pin_prev;
        trig = rise_sel ? (lvl & ~prv) : (~lvl & prv);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TRIG_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> (lvl != prv));  // R3
endmodule

// File: rtl/icap_counter.sv
module icap_counter
    import icap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic             cap_wr,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             top_sel,
    input  logic             trig,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap,
    output logic             wrap,
    output logic             cap_evt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic at_top;

    always_comb begin
        st_d    = st_q;
        at_top  = (top_sel && st_q.cnt == st_q.cap) || (st_q.cnt == {CNT_W{1'b1}});
        wrap    = !cnt_wr && at_top;
        cap_evt = trig && !top_sel;
        if (cnt_wr)      st_d.cnt = wr_val;
        else if (at_top) st_d.cnt = '0;
        else             st_d.cnt = st_q.cnt + 1'b1;
        if (cap_wr)       st_d.cap = wr_val;
        else if (cap_evt) st_d.cap = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign cap = st_q.cap;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && cnt != {CNT_W{1'b1}} && !(top_sel && cnt == cap))
        |=> cnt == $past(cnt) + 1'b1);  // R6
    AST_TOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (top_sel && !cnt_wr && cnt == cap) |=> cnt == '0);  // R7
    AST_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (top_sel && !cap_wr) |=> $stable(cap));  // R7
    AST_CAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !top_sel && !cap_wr) |=> cap == $past(cnt));  // R1
endmodule

// File: rtl/icap_irq.sv
module icap_irq
    import icap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_wr,
    input  logic             flag_wr,
    input  logic [BUS_W-1:0] wdata,
    input  logic [BUS_W-1:0] set_vec,
    input  logic             gie,
    output logic [BUS_W-1:0] mask,
    output logic [BUS_W-1:0] flags,
    output logic [BUS_W-1:0] irq
);
    typedef struct packed {
        logic [BUS_W-1:0] mask;
        logic [BUS_W-1:0] flag;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_wr) st_d.mask = wdata & IRQ_BITS;
        st_d.flag = (st_q.flag & ~(flag_wr ? (wdata & IRQ_BITS) : '0))
                  | (set_vec & IRQ_BITS);
        irq = gie ? (st_q.mask & st_q.flag) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask  = st_q.mask;
    assign flags = st_q.flag;

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |-> gie);  // R9
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[B_CAP] |=> flags[B_CAP]);  // R10
    AST_MASK_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask & ~IRQ_BITS) == '0);  // R8
endmodule

// File: rtl/icap_timer16.sv
module icap_timer16
    import icap_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADR_W-1:0] bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             cap_pin,
    input  logic             cmp_out,
    input  logic             cmpa_hit,
    input  logic             cmpb_hit,
    input  logic             gie,
    output logic             irq_cap,
    output logic             irq_cmpa,
    output logic             irq_cmpb,
    output logic             irq_ovf
);
    typedef struct packed {
        logic [BUS_W-1:0]  temp;
        logic [CTRL_W-1:0] ctrl;
    } top_st_t;

    top_st_t st_d, st_q;
    logic [CNT_W-1:0] cnt, cap;
    logic [BUS_W-1:0] mask, flags, irq, set_vec;
    logic trig, wrap, cap_evt;
    logic cnt_wr, cap_wr, mask_wr, flag_wr;

    always_comb begin
        st_d    = st_q;
        cnt_wr  = bus_wr && bus_addr == A_CNT_LO;
        cap_wr  = bus_wr && bus_addr == A_CAP_LO;
        mask_wr = bus_wr && bus_addr == A_MASK;
        flag_wr = bus_wr && bus_addr == A_FLAG;
        if (bus_wr && (bus_addr == A_CNT_HI || bus_addr == A_CAP_HI))
            st_d.temp = bus_wdata;
        else if (bus_rd && bus_addr == A_CNT_LO)
            st_d.temp = cnt[CNT_W-1:BUS_W];
        else if (bus_rd && bus_addr == A_CAP_LO)
            st_d.temp = cap[CNT_W-1:BUS_W];
        if (bus_wr && bus_addr == A_CTRL)
            st_d.ctrl = bus_wdata[CTRL_W-1:0];

        case (bus_addr)
            A_CNT_LO: bus_rdata = cnt[BUS_W-1:0];
            A_CAP_LO: bus_rdata = cap[BUS_W-1:0];
            A_CNT_HI,
            A_CAP_HI: bus_rdata = st_q.temp;
            A_CTRL:   bus_rdata = {{(BUS_W-CTRL_W){1'b0}}, st_q.ctrl};
            A_MASK:   bus_rdata = mask;
            A_FLAG:   bus_rdata = flags;
            default:  bus_rdata = '0;
        endcase

        set_vec         = '0;
        set_vec[B_CAP]  = cap_evt;
        set_vec[B_CMPB] = cmpb_hit;
        set_vec[B_CMPA] = cmpa_hit;
        set_vec[B_OVF]  = wrap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    icap_sync_edge #(.SYNC_N(SYNC_N)) i_sync (
        .clk(clk), .rst_n(rst_n), .pin_raw(cap_pin), .cmp_raw(cmp_out),
        .src_cmp(st_q.ctrl[C_SRC]), .rise_sel(st_q.ctrl[C_RISE]), .trig(trig)
    );

    icap_counter i_cnt (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cap_wr(cap_wr),
        .wr_val({st_q.temp, bus_wdata}), .top_sel(st_q.ctrl[C_TOP]),
        .trig(trig), .cnt(cnt), .cap(cap), .wrap(wrap), .cap_evt(cap_evt)
    );

    icap_irq i_irq (
        .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .flag_wr(flag_wr),
        .wdata(bus_wdata), .set_vec(set_vec), .gie(gie),
        .mask(mask), .flags(flags), .irq(irq)
    );

    assign irq_cap  = irq[B_CAP];
    assign irq_cmpa = irq[B_CMPA];
    assign irq_cmpb = irq[B_CMPB];
    assign irq_ovf  = irq[B_OVF];

    AST_TEMP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == A_CNT_LO)
        |=> st_q.temp == $past(cnt[CNT_W-1:BUS_W]));  // R4
    AST_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CNT_LO)
        |=> cnt == $past({st_q.temp, bus_wdata}));  // R5
endmodule

// File: tb/test_icap_timer16.sv
module test_icap_timer16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       cap_pin = 1'b0, cmp_out = 1'b0;
    logic       cmpa_hit = 1'b0, cmpb_hit = 1'b0, gie = 1'b0;
    logic       irq_cap, irq_cmpa, irq_cmpb, irq_ovf;
    int         n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    icap_timer16 i_icap_timer16 (.*);

    function automatic logic [15:0] exp_cap(logic [15:0] v, int m);
        return v + 16'(m) + 16'd2;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1; #2 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wr16(logic [2:0] lo, logic [15:0] v);
        wr(lo + 3'd1, v[15:8]); wr(lo, v[7:0]);
    endtask

    task automatic rd16(logic [2:0] lo, output logic [15:0] v);
        logic [7:0] l, h;
        rd(lo, l); rd(lo + 3'd1, h); v = {h, l};
    endtask

    task automatic settle(); repeat (5) @(negedge clk); endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w, v, t;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd(3'd5, b); check("R8 mask reset", 16'(b), 16'h0);
        rd(3'd6, b); check("R10 flag reset", 16'(b), 16'h0);
        rd16(3'd2, w); check("R1 capture reset", w, 16'h0);
        rd(3'd4, b); check("R2 ctrl reset", 16'(b), 16'h0);

        // Mask layout
        wr(3'd5, 8'hFF); rd(3'd5, b); check("R8 mask reserved bits", 16'(b), 16'h27);

        // Atomic read across a high-byte rollover
        wr16(3'd0, 16'h12FE);
        rd(3'd0, b); check("R4 low byte", 16'(b), 16'h00FE);
        settle();
        rd(3'd1, b); check("R4 latched high", 16'(b), 16'h0012);

        // Lone high-byte write leaves the counter alone
        wr16(3'd0, 16'h0100);
        wr(3'd1, 8'h77);
        rd16(3'd0, w); check("R5 high write only temp", w, 16'h0101);

        // Overflow wrap
        wr16(3'd0, 16'hFFFE);
        wr(3'd6, 8'h27);
        rd(3'd6, b); check("R6 no early overflow", 16'(b & 8'h01), 16'h0);
        rd(3'd6, b); check("R6 overflow flag", 16'(b & 8'h01), 16'h1);

        // Random captures over source and edge
        for (int i = 0; i < 40; i++) begin
            logic src, rise;
            int m;
            src  = 1'($urandom);
            rise = 1'($urandom);
            m    = int'($urandom % 8);
            v    = 16'($urandom);
            if (src) cmp_out = ~rise; else cap_pin = ~rise;
            settle();
            wr(3'd4, {6'd0, rise, src});
            wr(3'd6, 8'h20);
            // toggle the unselected source
            if (src) cap_pin = ~cap_pin; else cmp_out = ~cmp_out;
            settle();
            rd(3'd6, b); check("R2 unselected source ignored", 16'(b & 8'h20), 16'h0);
            wr16(3'd0, v);
            repeat (m) @(negedge clk);
            if (src) cmp_out = rise; else cap_pin = rise;
            settle();
            rd16(3'd2, w); check("R1 captured value", w, exp_cap(v, m));
            rd(3'd6, b); check("R1 capture flag", 16'(b & 8'h20), 16'h20);
            if (src) cmp_out = ~rise; else cap_pin = ~rise;
            settle();
            rd16(3'd2, t); check("R3 opposite edge ignored", t, exp_cap(v, m));
        end

        // TOP mode
        cap_pin = 1'b0; settle();
        wr(3'd4, 8'h04);
        wr16(3'd2, 16'h0040);
        wr16(3'd0, 16'h003B);
        wr(3'd6, 8'h27);
        repeat (6) @(negedge clk);
        rd16(3'd0, w); check("R7 wrap at capture value", w, 16'h0001);
        rd(3'd6, b); check("R7 overflow flag at TOP", 16'(b & 8'h01), 16'h1);
        cap_pin = 1'b1; settle(); cap_pin = 1'b0; settle();
        rd16(3'd2, w); check("R7 capture frozen", w, 16'h0040);
        rd(3'd6, b); check("R7 no capture flag", 16'(b & 8'h20), 16'h0);
        wr(3'd4, 8'h00);

        // Interrupt gating
        wr(3'd5, 8'h27); wr(3'd6, 8'h27);
        gie = 1'b0;
        cmpa_hit = 1'b1; @(negedge clk); cmpa_hit = 1'b0;
        check("R9 gie low blocks", 16'(irq_cmpa), 16'h0);
        rd(3'd6, b); check("R10 cmpa flag", 16'(b & 8'h06), 16'h02);
        gie = 1'b1; #1;
        check("R9 cmpa irq", 16'({irq_cap, irq_cmpb, irq_cmpa}), 16'h1);
        wr(3'd5, 8'h25); #1;
        check("R9 mask blocks", 16'(irq_cmpa), 16'h0);
        wr(3'd5, 8'h27);
        cmpb_hit = 1'b1; wr(3'd6, 8'h02); cmpb_hit = 1'b0; #1;
        check("R10 write-one clear", 16'({irq_cmpb, irq_cmpa}), 16'h2);
        gie = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule